// File: doc/BRIEF.md
# Strip Cluster Centroid Finder

The block takes a stream of strip samples, each an address and an amplitude, in rising address order. Samples whose addresses follow each other without a gap form one cluster. For each cluster it finds the strip with the largest amplitude and builds a window around it. The window is five strips wide when two cluster strips exist on each side of that strip, and three strips wide otherwise. It then computes a weighted centroid with two fractional bits and sends one result per cluster.

The centroid is referenced to the second strip of the window. A sequential restoring divider does the division, one quotient bit per cycle. The input marker `in_last` ends an event and closes the open cluster, so clusters never span two events.

Both data interfaces are valid/ready. A sample moves when `in_valid` and `in_ready` are both high at a rising edge. A result moves when `out_valid` and `out_ready` are both high. Once `out_valid` is raised, the result and its flag stay stable until they are taken. While a cluster is being divided or a result waits to leave, `in_ready` is low, so a stalled consumer stalls the producer and no sample is lost.

Top module: `strip_centroid`

## Requirements
- R1: A sample is taken only on a rising edge with `in_valid` and `in_ready` both high. While `out_valid` is high, `in_ready` is low.
- R2: A sample joins the open cluster only if its address equals the previous address plus one and the previous address is not the all-ones address. Any other sample closes the open cluster and starts a new one. A sample with `in_last` high joins or starts a cluster as above, and that cluster is then closed.
- R3: The peak is the strip with the largest amplitude. When amplitudes tie, the earliest (lowest address) strip wins.
- R4: The window is five strips (D1..D5, peak at D3) when the cluster holds two strips before and two strips after the peak, and `out_five` is then 1. Otherwise the window is three strips (D2..D4, peak at D3), strips outside the cluster count as zero, and `out_five` is 0.
- R5: Five-strip result: `out_pos` = 4*(peak-1) + trunc(4*(-D1+D3+2*D4+3*D5) / (D1+D2+D3+D4+D5)). Division truncates toward zero.
- R6: Three-strip result: `out_pos` = 4*peak + trunc(4*(D4-D2) / (D2+D3+D4)). Division truncates toward zero.
- R7: When the window amplitudes sum to zero, `out_pos` = 4*peak and no division is run.
- R8: Each cluster gives exactly one result, and results leave in cluster order. This includes single-strip clusters and a cluster closed by `in_last` on the same sample that opened it.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_pos` and `out_five` hold their values. After a result is taken, `out_valid` falls on the next cycle.
- R10: After reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample valid |
| in_ready | output | 1 | Block can take a sample |
| in_addr | input | AW | Strip address |
| in_data | input | DW | Strip amplitude |
| in_last | input | 1 | Last sample of the event |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_pos | output | AW+2 | Centroid in quarter strips (address times 4 plus offset) |
| out_five | output | 1 | 1 for a five-strip window, 0 for a three-strip window |

## Verification
The bench targets the following corner cases, each paired with the fault it would expose:
- An amplitude tie: a design that picks the later strip reports a position one quarter strip off.
- An address step from all-ones to zero: a design that treats it as contiguous merges two clusters into one result.
- A sample that both opens a new cluster and ends the event: a design that misses this case drops a result.
- An all-zero cluster: a design that divides anyway produces a garbage offset.
- Negative offsets: a design that rounds toward minus infinity lands one step low.

A second pass with `out_ready` toggling checks that stalls change neither the results nor their order.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_OUT} st_e;

  function automatic logic [1:0] sat_inc2(input logic [1:0] c);
    return (c == 2'd2) ? 2'd2 : c + 2'd1;
  endfunction
endpackage

// File: rtl/sc_collector.sv
module sc_collector
  import sc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [AW-1:0]        in_addr,
  input  logic [DW-1:0]        in_data,
  input  logic                 in_last,
  output logic                 in_ready,
  input  logic                 back_idle,
  output logic                 emit,
  output logic [AW-1:0]        em_addr,
  output logic [4:0][DW-1:0]   em_d,
  output logic                 em_five
);
  logic                 active, flush;
  logic [AW-1:0]        last_addr;
  logic [DW-1:0]        h1, h2;
  logic [1:0]           hc;
  logic [AW-1:0]        cur_pa, nxt_pa;
  logic [4:0][DW-1:0]   cur_d, nxt_d;
  logic [1:0]           cur_nb, cur_na, nxt_nb, nxt_na;
  logic                 fire, contig, gap_close;

  assign in_ready  = back_idle && !flush;
  assign fire      = in_valid && in_ready;
  assign contig    = active && (in_addr == last_addr + AW'(1)) && (last_addr != '1);
  assign gap_close = fire && active && !contig;

  // cluster state after absorbing the offered sample
  always_comb begin
    nxt_pa = cur_pa; nxt_d = cur_d; nxt_nb = cur_nb; nxt_na = cur_na;
    if (!contig) begin
      nxt_pa = in_addr;
      nxt_d  = '0;
      nxt_d[2] = in_data;
      nxt_nb = 2'd0;
      nxt_na = 2'd0;
    end else if (in_data > cur_d[2]) begin
      nxt_pa   = in_addr;
      nxt_d[2] = in_data;
      nxt_d[1] = h1;
      nxt_d[0] = h2;
      nxt_d[3] = '0;
      nxt_d[4] = '0;
      nxt_nb   = hc;
      nxt_na   = 2'd0;
    end else if (cur_na == 2'd0) begin
      nxt_d[3] = in_data;
      nxt_na   = 2'd1;
    end else if (cur_na == 2'd1) begin
      nxt_d[4] = in_data;
      nxt_na   = 2'd2;
    end
  end

  always_comb begin
    emit = (flush && back_idle) || gap_close || (fire && in_last);
    if (flush || gap_close) begin
      em_addr = cur_pa; em_d = cur_d;
      em_five = (cur_nb == 2'd2) && (cur_na == 2'd2);
    end else begin
      em_addr = nxt_pa; em_d = nxt_d;
      em_five = (nxt_nb == 2'd2) && (nxt_na == 2'd2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; flush <= 1'b0; last_addr <= '0;
      h1 <= '0; h2 <= '0; hc <= 2'd0;
      cur_pa <= '0; cur_d <= '0; cur_nb <= 2'd0; cur_na <= 2'd0;
    end else begin
      if (flush && back_idle) flush <= 1'b0;
      if (fire) begin
        cur_pa    <= nxt_pa;
        cur_d     <= nxt_d;
        cur_nb    <= nxt_nb;
        cur_na    <= nxt_na;
        last_addr <= in_addr;
        h1        <= in_data;
        h2        <= contig ? h1 : '0;
        hc        <= contig ? sat_inc2(hc) : 2'd1;
        active    <= !in_last;
        if (gap_close && in_last) flush <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/sc_div.sv
module sc_div #(
  parameter int NW = 13
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] dividend,
  input  logic [NW-1:0] divisor,
  output logic          done,
  output logic [NW-1:0] quo
);
  localparam int CW = $clog2(NW + 1);
  logic [NW-1:0] rem, dsr;
  logic [CW-1:0] cnt;
  logic          busy;
  logic [NW:0]   sh;

  assign sh  = {rem, quo[NW-1]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem <= '0; quo <= '0; dsr <= '0; cnt <= '0; busy <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem  <= '0;
        quo  <= dividend;
        dsr  <= divisor;
        cnt  <= CW'(NW);
        busy <= 1'b1;
      end else if (busy) begin
        if (sh >= {1'b0, dsr}) begin
          rem <= NW'(sh - {1'b0, dsr});
          quo <= {quo[NW-2:0], 1'b1};
        end else begin
          rem <= sh[NW-1:0];
          quo <= {quo[NW-2:0], 1'b0};
        end
        cnt <= cnt - CW'(1);
        if (cnt == CW'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/strip_centroid.sv
module strip_centroid
  import sc_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [AW-1:0] in_addr,
  input  logic [DW-1:0] in_data,
  input  logic          in_last,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW+1:0] out_pos,
  output logic          out_five
);
  localparam int SW = DW + 4;   // signed weighted sum
  localparam int NW = SW + 1;   // dividend with two fraction bits
  localparam int PW = AW + 2;

  st_e                state;
  logic               emit, em_five, div_done, neg_q, start_div;
  logic [AW-1:0]      em_addr, base_q;
  logic [4:0][DW-1:0] em_d;
  logic signed [SW-1:0] e [5];
  logic signed [SW-1:0] num_s, mag;
  logic [NW-1:0]      den, dividend, quo;
  logic [PW-1:0]      pos_q, off;

  sc_collector #(.AW(AW), .DW(DW)) u_col (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
    .back_idle(state == ST_IDLE), .emit(emit), .em_addr(em_addr),
    .em_d(em_d), .em_five(em_five)
  );

  for (genvar k = 0; k < 5; k++) begin : g_ext
    assign e[k] = SW'(em_d[k]);
  end

  always_comb begin
    if (em_five) begin
      num_s = e[2] + e[3] + e[3] + e[4] + e[4] + e[4] - e[0];
      den   = NW'(em_d[0]) + NW'(em_d[1]) + NW'(em_d[2]) + NW'(em_d[3]) + NW'(em_d[4]);
    end else begin
      num_s = e[3] - e[1];
      den   = NW'(em_d[1]) + NW'(em_d[2]) + NW'(em_d[3]);
    end
    mag      = num_s[SW-1] ? -num_s : num_s;
    dividend = {mag[SW-2:0], 2'b00};
  end

  assign start_div = emit && (den != '0);

  sc_div #(.NW(NW)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start_div), .dividend(dividend),
    .divisor(den), .done(div_done), .quo(quo)
  );

  assign off = neg_q ? -PW'(quo) : PW'(quo);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE; pos_q <= '0; out_five <= 1'b0; neg_q <= 1'b0; base_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (emit) begin
          out_five <= em_five;
          if (den == '0) begin
            pos_q <= {em_addr, 2'b00};
            state <= ST_OUT;
          end else begin
            neg_q  <= num_s[SW-1];
            base_q <= em_five ? em_addr - AW'(1) : em_addr;
            state  <= ST_DIV;
          end
        end
        ST_DIV: if (div_done) begin
          pos_q <= {base_q, 2'b00} + off;
          state <= ST_OUT;
        end
        ST_OUT: if (out_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = (state == ST_OUT);
  assign out_pos   = pos_q;
endmodule

// File: rtl/strip_centroid_chk.sv
module strip_centroid_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_ready,
  input logic          out_valid,
  input logic          out_ready,
  input logic [PW-1:0] out_pos,
  input logic          out_five
);
  a_r1_no_take_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  a_r9_valid_holds: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid);

  a_r9_payload_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> $stable(out_pos) && $stable(out_five));

  a_r8_single_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready |=> !out_valid);
endmodule

bind strip_centroid strip_centroid_chk #(.PW(AW + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_pos(out_pos), .out_five(out_five)
);

// File: tb/tb_strip_centroid.sv
module tb_strip_centroid;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int PW = AW + 2;
  localparam int NV = 21;
  // each entry: {last, addr, data}
  localparam logic [16:0] STIM [NV] = '{
    {1'b0, 8'd10, 8'd10}, {1'b0, 8'd11, 8'd20}, {1'b0, 8'd12, 8'd40},
    {1'b0, 8'd13, 8'd20}, {1'b1, 8'd14, 8'd10},                       // five, symmetric
    {1'b0, 8'd30, 8'd50}, {1'b0, 8'd31, 8'd20}, {1'b0, 8'd32, 8'd10},
    {1'b0, 8'd33, 8'd5},                                              // peak first: three
    {1'b1, 8'd40, 8'd0},                                              // gap, zero sum, last
    {1'b0, 8'd50, 8'd30}, {1'b0, 8'd51, 8'd30}, {1'b1, 8'd52, 8'd10}, // tie
    {1'b0, 8'd60, 8'd5},  {1'b0, 8'd61, 8'd10}, {1'b0, 8'd62, 8'd80},
    {1'b0, 8'd63, 8'd40}, {1'b1, 8'd64, 8'd30},                       // five, asymmetric
    {1'b0, 8'd254, 8'd10}, {1'b0, 8'd255, 8'd20}, {1'b1, 8'd0, 8'd30} // wrap + gap-last
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b1;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, out_valid, out_five;
  logic [PW-1:0] out_pos;
  logic bp = 1'b0;
  int checks = 0, bad = 0;
  int exp_pos [32], exp_five [32], exp_tag [32];
  int n_exp = 0;
  int got_pos [32], got_five [32];
  int n_got = 0;
  int rl;
  int ra [16], rd [16];
  int bp_cnt = 0;

  always #5 clk = ~clk;

  strip_centroid #(.AW(AW), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_addr(in_addr), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_pos(out_pos), .out_five(out_five)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int dget(input int k);
    return (k >= 0 && k < rl) ? rd[k] : 0;
  endfunction

  // reference: whole-run model built from the requirements
  task automatic close_run();
    int pk, num, den, base, five;
    pk = 0;
    for (int k = 1; k < rl; k++) if (rd[k] > rd[pk]) pk = k;
    five = (pk >= 2 && pk + 2 < rl) ? 1 : 0;
    if (five == 1) begin
      num  = -dget(pk-2) + dget(pk) + 2*dget(pk+1) + 3*dget(pk+2);
      den  = dget(pk-2) + dget(pk-1) + dget(pk) + dget(pk+1) + dget(pk+2);
      base = ra[pk] - 1;
    end else begin
      num  = dget(pk+1) - dget(pk-1);
      den  = dget(pk-1) + dget(pk) + dget(pk+1);
      base = ra[pk];
    end
    if (den == 0) begin
      exp_pos[n_exp] = 4*ra[pk]; exp_tag[n_exp] = 7;
    end else begin
      exp_pos[n_exp] = 4*base + (4*num)/den; exp_tag[n_exp] = five ? 5 : 6;
    end
    exp_five[n_exp] = five;
    n_exp++;
  endtask

  task automatic build_model();
    int prev; bit act;
    act = 0; prev = 0; rl = 0;
    for (int i = 0; i < NV; i++) begin
      int a, d; bit l;
      l = STIM[i][16]; a = int'(STIM[i][15:8]); d = int'(STIM[i][7:0]);
      if (act && a == prev + 1 && prev != 255) begin
        ra[rl] = a; rd[rl] = d; rl++;
      end else begin
        if (act) close_run();
        rl = 1; ra[0] = a; rd[0] = d;
      end
      prev = a; act = 1;
      if (l) begin close_run(); act = 0; end
    end
  endtask

  task automatic send(input logic [16:0] w);
    @(posedge clk); #1;
    in_valid = 1'b1; in_last = w[16]; in_addr = w[15:8]; in_data = w[7:0];
    forever begin
      @(negedge clk);
      if (in_ready) break;
      @(posedge clk); #1;
    end
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // output monitor, sampled mid-cycle
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready && n_got < 32) begin
      got_pos[n_got] = int'(out_pos); got_five[n_got] = int'(out_five); n_got++;
    end
  end

  // consumer back-pressure pattern
  initial forever begin
    @(posedge clk); #1;
    bp_cnt++;
    out_ready = bp ? ((bp_cnt % 5) == 0 || (bp_cnt % 7) == 3) : 1'b1;
  end

  task automatic run_pass(input string tag);
    n_got = 0;
    for (int i = 0; i < NV; i++) send(STIM[i]);
    for (int t = 0; t < 3000 && n_got < n_exp; t++) @(posedge clk);
    repeat (20) @(posedge clk);
    check(n_got == n_exp, "R8 result count", n_got, n_exp);
    for (int i = 0; i < n_exp && i < n_got; i++) begin
      string r;
      r = (exp_tag[i] == 5) ? "R5 R2 R3" : (exp_tag[i] == 6) ? "R6 R2 R3" : "R7 R2";
      check(got_pos[i] == exp_pos[i], {tag, " ", r, " position"}, got_pos[i], exp_pos[i]);
      check(got_five[i] == exp_five[i], {tag, " R4 width flag"}, got_five[i], exp_five[i]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; checks++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    build_model();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R10 out_valid after reset", int'(out_valid), 0);
    check(in_ready == 1'b1, "R10 in_ready after reset", int'(in_ready), 1);
    // hand-derived spot values: symmetric five at 12, tie keeps the first strip (R3)
    check(exp_pos[0] == 48, "R5 model symmetric", exp_pos[0], 48);
    check(exp_pos[3] == 202, "R3 model tie", exp_pos[3], 202);
    run_pass("free");
    bp = 1'b1;
    // R1 R9: a stalled result blocks intake and holds its value
    fork
      run_pass("stall");
      begin
        bit seen; seen = 0;
        for (int t = 0; t < 4000 && !seen; t++) begin
          @(negedge clk);
          if (out_valid && !out_ready) begin
            logic [PW-1:0] p0; p0 = out_pos; seen = 1;
            check(in_ready == 1'b0, "R1 intake blocked while pending", int'(in_ready), 0);
            @(negedge clk);
            check(out_valid == 1'b1, "R9 valid held under stall", int'(out_valid), 1);
            check(out_pos == p0, "R9 position held under stall", int'(out_pos), int'(p0));
          end
        end
      end
    join
    bp = 1'b0;
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule